// File: doc/BRIEF.md
# Single-Cycle Broadcast Bypass for a Five-Port Mesh Router

This block holds the switch control of a virtual-channel router in a 2D mesh. It has five ports, numbered North=0, East=1, South=2, West=3 and Local=4. A quiet router gets no benefit from its pipeline stages. So when exactly one flit arrives at an otherwise empty router, the flit is copied onto every output except the port it came in on, in the cycle it arrives. Dimension-ordered XY route computation runs at the same time. In the next cycle the one correct output receives an acknowledge, and every other output that carried a copy receives a kill, so its downstream receiver throws the copy away.

Any other arrival is written into a one-entry holding slot of its input. This covers several flits in one cycle, a flit arriving while the router is busy, and a flit facing an output without credit. Held flits go through route computation, VC allocation, switch allocation and switch traversal, one flit at a time, with the lowest-numbered port served first. Each output's credit state is reduced to a single ready flag. The upstream side must not send a second flit on an input whose slot has not yet been forwarded.

The controller is a state machine with six states:
- `ST_IDLE`: waiting.
- `ST_CONFIRM`: the ack/kill cycle that follows any traversal.
- `ST_ROUTE`, `ST_VCALLOC`, `ST_SWALLOC` and `ST_TRAVERSE`: the stages of the conventional path.

Its transitions are:
- IDLE→CONFIRM on a broadcast.
- IDLE→ROUTE or CONFIRM→ROUTE when a flit is held.
- CONFIRM→IDLE when nothing is held.
- ROUTE→VCALLOC→SWALLOC.
- SWALLOC stays in SWALLOC until the routed output is ready, then goes to TRAVERSE.
- TRAVERSE→CONFIRM.

Top module: `mcast_bypass_router`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid, out_ack and out_kill are all zero.
- R2: A broadcast starts in a cycle where all of these hold: exactly one in_valid bit is set, the router is in ST_IDLE with no held flit, every output other than the arrival port has out_ready high, and the computed route is not the arrival port. In that same cycle out_valid is set on every port except the arrival port, and each of those ports carries the arriving flit's data and VC id.
- R3: The route uses destination X in data bits [3:0] and destination Y in data bits [7:4]. The router's own coordinates are MY_X and MY_Y. The route is East if X is greater, West if X is smaller, then North if Y is greater, South if Y is smaller, and Local if both match.
- R4: One cycle after any cycle with out_valid set, exactly one out_ack bit is set, and it is the computed route port.
- R5: In a broadcast's ack cycle, out_kill is set on every copy port except the route. Kill is never set for a conventional traversal, and never on the same port as ack.
- R6: When two or more flits arrive in one cycle, none is broadcast. Each one later appears alone on its route port, lowest port number first.
- R7: If any candidate output is not ready, the single arrival is not broadcast and takes the conventional path.
- R8: A conventional flit arriving in cycle c with its route ready appears on its route port alone in cycle c+4. Its ack follows in cycle c+5.
- R9: While any flit is held or in flight, a new lone arrival is not broadcast but is held. After a traversal's ack cycle, the next held flit starts route computation in the following cycle.
- R10: In an ack cycle, no output is valid.
- R11: A held flit in switch allocation waits until its route port's out_ready is high. Traversal follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Flit present per input port |
| in_data | input | 5x32 | Flit payload per input, destination in low byte |
| in_vc | input | 5x2 | VC id per input |
| out_ready | input | 5 | Credit available per output port |
| out_valid | output | 5 | Flit copy driven per output |
| out_data | output | 5x32 | Payload per output |
| out_vc | output | 5x2 | VC id per output |
| out_ack | output | 5 | Confirms the previous cycle's flit on that port |
| out_kill | output | 5 | Discards the previous cycle's copy on that port |

## Verification
The bench sends lone flits from each side toward each XY direction, including Local. A wrong route decode would acknowledge a copy that should be killed, and a wrong candidate mask would echo the flit back on its arrival port. It then makes two flits arrive together and adds a third while the router is busy. A design that broadcast anyway, or served the held flits in the wrong order or at the wrong cycle, would miss the scoreboard's timing. The last two tests withdraw credit: one on a non-route port, where a broadcast would overrun an output with no credit, and one on the route port itself, where traversal must stall until that output is ready again.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    localparam int NPORT  = 5;
    localparam int PIDX_W = $clog2(NPORT);

    localparam int P_NORTH = 0;
    localparam int P_EAST  = 1;
    localparam int P_SOUTH = 2;
    localparam int P_WEST  = 3;
    localparam int P_LOCAL = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONFIRM,
        ST_ROUTE,
        ST_VCALLOC,
        ST_SWALLOC,
        ST_TRAVERSE
    } rstate_t;

    function automatic logic [PIDX_W-1:0] first_set(input logic [NPORT-1:0] m);
        logic [PIDX_W-1:0] r;
        r = '0;
        for (int i = NPORT-1; i >= 0; i--) begin
            if (m[i]) r = PIDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [NPORT-1:0] port_bit(input logic [PIDX_W-1:0] p);
        return NPORT'(1) << p;
    endfunction

endpackage

// File: rtl/xy_route.sv
module xy_route
    import mcb_pkg::*;
#(
    parameter int COORD_W = 4,
    parameter int MY_X    = 1,
    parameter int MY_Y    = 1
) (
    input  logic [2*COORD_W-1:0] dest,
    output logic [NPORT-1:0]     dir
);
    localparam logic [COORD_W-1:0] HOME_X = COORD_W'(MY_X);
    localparam logic [COORD_W-1:0] HOME_Y = COORD_W'(MY_Y);

    logic [COORD_W-1:0] dx, dy;
    assign dx = dest[COORD_W-1:0];
    assign dy = dest[2*COORD_W-1:COORD_W];

    always_comb begin
        dir = '0;
        if (dx > HOME_X)      dir[P_EAST]  = 1'b1;
        else if (dx < HOME_X) dir[P_WEST]  = 1'b1;
        else if (dy > HOME_Y) dir[P_NORTH] = 1'b1;
        else if (dy < HOME_Y) dir[P_SOUTH] = 1'b1;
        else                  dir[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/flit_slots.sv
module flit_slots
    import mcb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int VC_W   = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0]             wr_en,
    input  logic [NPORT-1:0][DATA_W-1:0] wr_data,
    input  logic [NPORT-1:0][VC_W-1:0]   wr_vc,
    input  logic [NPORT-1:0]             clr,
    output logic [NPORT-1:0]             held,
    output logic [NPORT-1:0][DATA_W-1:0] held_data,
    output logic [NPORT-1:0][VC_W-1:0]   held_vc
);
    for (genvar g = 0; g < NPORT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                held[g]      <= 1'b0;
                held_data[g] <= '0;
                held_vc[g]   <= '0;
            end else if (wr_en[g]) begin
                held[g]      <= 1'b1;
                held_data[g] <= wr_data[g];
                held_vc[g]   <= wr_vc[g];
            end else if (clr[g]) begin
                held[g]      <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mcast_bypass_router.sv
module mcast_bypass_router
    import mcb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int VC_W    = 2,
    parameter int COORD_W = 4,
    parameter int MY_X    = 1,
    parameter int MY_Y    = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0]             in_valid,
    input  logic [NPORT-1:0][DATA_W-1:0] in_data,
    input  logic [NPORT-1:0][VC_W-1:0]   in_vc,
    input  logic [NPORT-1:0]             out_ready,
    output logic [NPORT-1:0]             out_valid,
    output logic [NPORT-1:0][DATA_W-1:0] out_data,
    output logic [NPORT-1:0][VC_W-1:0]   out_vc,
    output logic [NPORT-1:0]             out_ack,
    output logic [NPORT-1:0]             out_kill
);
    localparam int DEST_W = 2 * COORD_W;

    rstate_t           state_q, state_d;
    logic [PIDX_W-1:0] sel_q, sel_d;
    logic [NPORT-1:0]  route_q, route_d;
    logic [NPORT-1:0]  ack_q, ack_d;
    logic [NPORT-1:0]  kill_q, kill_d;

    logic [NPORT-1:0]             arr;
    logic [PIDX_W-1:0]            arr_idx;
    logic [NPORT-1:0]             cand;
    logic [NPORT-1:0]             mc_dir;
    logic [NPORT-1:0]             held_dir;
    logic                         mc_go;
    logic [NPORT-1:0]             wr_en, clr, pend;
    logic [NPORT-1:0]             held;
    logic [NPORT-1:0][DATA_W-1:0] held_data;
    logic [NPORT-1:0][VC_W-1:0]   held_vc;

    assign arr     = in_valid & {NPORT{~rst}};
    assign arr_idx = first_set(arr);
    assign cand    = ~port_bit(arr_idx);

    xy_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_mc_route (
        .dest (in_data[arr_idx][DEST_W-1:0]),
        .dir  (mc_dir)
    );

    xy_route #(.COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_held_route (
        .dest (held_data[sel_q][DEST_W-1:0]),
        .dir  (held_dir)
    );

    assign mc_go = (state_q == ST_IDLE) && (held == '0) && $onehot(arr)
                && ((cand & ~out_ready) == '0) && ((mc_dir & cand) != '0);

    assign wr_en = arr & {NPORT{~mc_go}};
    assign clr   = (state_q == ST_TRAVERSE) ? port_bit(sel_q) : '0;
    assign pend  = held | wr_en;

    flit_slots #(.DATA_W(DATA_W), .VC_W(VC_W)) u_slots (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (in_data),
        .wr_vc     (in_vc),
        .clr       (clr),
        .held      (held),
        .held_data (held_data),
        .held_vc   (held_vc)
    );

    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        route_d = route_q;
        ack_d   = ack_q;
        kill_d  = kill_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mc_go) begin
                    state_d = ST_CONFIRM;
                    ack_d   = mc_dir;
                    kill_d  = cand & ~mc_dir;
                end else if (pend != '0) begin
                    state_d = ST_ROUTE;
                    sel_d   = first_set(pend);
                end
            end
            ST_CONFIRM: begin
                if (pend != '0) begin
                    state_d = ST_ROUTE;
                    sel_d   = first_set(pend);
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_ROUTE: begin
                route_d = held_dir;
                state_d = ST_VCALLOC;
            end
            ST_VCALLOC: state_d = ST_SWALLOC;
            ST_SWALLOC: begin
                if ((route_q & out_ready) != '0) state_d = ST_TRAVERSE;
            end
            ST_TRAVERSE: begin
                state_d = ST_CONFIRM;
                ack_d   = route_q;
                kill_d  = '0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
            route_q <= '0;
            ack_q   <= '0;
            kill_q  <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            route_q <= route_d;
            ack_q   <= ack_d;
            kill_q  <= kill_d;
        end
    end

    always_comb begin
        out_valid = '0;
        out_ack   = '0;
        out_kill  = '0;
        if (mc_go) begin
            out_valid = cand;
        end else if (state_q == ST_TRAVERSE) begin
            out_valid = route_q;
        end
        if (state_q == ST_CONFIRM) begin
            out_ack  = ack_q;
            out_kill = kill_q;
        end
        for (int p = 0; p < NPORT; p++) begin
            out_data[p] = mc_go ? in_data[arr_idx] : held_data[sel_q];
            out_vc[p]   = mc_go ? in_vc[arr_idx]   : held_vc[sel_q];
        end
    end
endmodule

// File: rtl/mcast_bypass_chk.sv
module mcast_bypass_chk
    import mcb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NPORT-1:0] in_valid,
    input logic [NPORT-1:0] out_ready,
    input logic [NPORT-1:0] out_valid,
    input logic [NPORT-1:0] out_ack,
    input logic [NPORT-1:0] out_kill
);
    // R4: a flit on any output is confirmed on exactly one port next cycle
    a_r4_one_ack: assert property (@(posedge clk) disable iff (rst)
        (out_valid != '0) |=> $onehot(out_ack));

    // R4: ack or kill only where a copy was driven the cycle before
    a_r4_ack_has_copy: assert property (@(posedge clk) disable iff (rst)
        (((out_ack | out_kill) & ~$past(out_valid)) == '0));

    // R5: never both ack and kill on one port
    a_r5_kill_excl: assert property (@(posedge clk) disable iff (rst)
        ((out_ack & out_kill) == '0));

    // R5: kills only follow a broadcast
    a_r5_kill_after_bcast: assert property (@(posedge clk) disable iff (rst)
        (out_kill != '0) |-> $past($countones(out_valid) > 1));

    // R2: a broadcast needs exactly one arrival
    a_r2_single_arrival: assert property (@(posedge clk) disable iff (rst)
        ($countones(out_valid) > 1) |-> $onehot(in_valid));

    // R7: a broadcast drives no port lacking credit
    a_r7_bcast_credit: assert property (@(posedge clk) disable iff (rst)
        ($countones(out_valid) > 1) |-> ((out_valid & ~out_ready) == '0));

    // R10: the ack cycle carries no flit
    a_r10_quiet_confirm: assert property (@(posedge clk) disable iff (rst)
        (out_ack != '0) |-> (out_valid == '0));
endmodule

bind mcast_bypass_router mcast_bypass_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_ack   (out_ack),
    .out_kill  (out_kill)
);

// File: tb/tb_mcast_bypass_router.sv
`timescale 1ns/1ps
module tb_mcast_bypass_router;
    localparam int NP = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     in_valid = '0;
    logic [NP-1:0][31:0] in_data = '0;
    logic [NP-1:0][1:0]  in_vc = '0;
    logic [NP-1:0]     out_ready = '1;
    logic [NP-1:0]     out_valid;
    logic [NP-1:0][31:0] out_data;
    logic [NP-1:0][1:0]  out_vc;
    logic [NP-1:0]     out_ack;
    logic [NP-1:0]     out_kill;

    mcast_bypass_router dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_vc(in_vc), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_vc(out_vc), .out_ack(out_ack),
        .out_kill(out_kill)
    );

    always #2 clk = ~clk;

    typedef struct {
        int           cyc;
        logic [NP-1:0] vm;
        logic [NP-1:0] ack;
        logic [NP-1:0] kill;
        logic [31:0]  data;
        logic [1:0]   vc;
        string        req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int dx, int dy, int tag);
        return {tag[23:0], dy[3:0], dx[3:0]};
    endfunction

    task automatic put(int p, logic [31:0] d, logic [1:0] v);
        in_valid[p] = 1'b1;
        in_data[p]  = d;
        in_vc[p]    = v;
    endtask

    task automatic want(int c, logic [NP-1:0] vm, logic [NP-1:0] ack,
                        logic [NP-1:0] kill, logic [31:0] d, logic [1:0] v, string req);
        exp_t e;
        e.cyc = c; e.vm = vm; e.ack = ack; e.kill = kill; e.data = d; e.vc = v; e.req = req;
        q.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
        in_valid = '0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: samples just before each rising edge
    initial begin
        logic [NP-1:0] w_ack, w_kill;
        bit   due;
        string due_req;
        exp_t e;
        due = 1'b0;
        w_ack = '0; w_kill = '0; due_req = "";
        forever begin
            @(negedge clk);
            #1;
            if (mon_en) begin
                if (due) begin
                    check(out_ack == w_ack, due_req, "ack", 64'(out_ack), 64'(w_ack));
                    check(out_kill == w_kill, due_req, "kill", 64'(out_kill), 64'(w_kill));
                    check(out_valid == '0, "R10", "valid in ack cycle", 64'(out_valid), 64'd0);
                    due = 1'b0;
                end else if ((out_ack | out_kill) != '0) begin
                    check(1'b0, "R4", "stray ack/kill", 64'(out_ack | out_kill), 64'd0);
                end
                if (out_valid != '0) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R2", "unexpected valid", 64'(out_valid), 64'd0);
                    end else begin
                        e = q.pop_front();
                        check(cyc == e.cyc, e.req, "cycle", 64'(cyc), 64'(e.cyc));
                        check(out_valid == e.vm, e.req, "valid mask", 64'(out_valid), 64'(e.vm));
                        for (int p = 0; p < NP; p++) begin
                            if (e.vm[p]) begin
                                check(out_data[p] == e.data, e.req, "data", 64'(out_data[p]), 64'(e.data));
                                check(out_vc[p] == e.vc, e.req, "vc", 64'(out_vc[p]), 64'(e.vc));
                            end
                        end
                        w_ack = e.ack; w_kill = e.kill; due_req = e.req; due = 1'b1;
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(4 * 20000);
        if (!done) begin
            check(1'b0, "R8", "watchdog", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c;
        logic [31:0] d1, d2, d3;
        settle(3);
        #1;
        check(out_valid == '0 && out_ack == '0 && out_kill == '0, "R1", "outputs in reset",
              64'({out_valid, out_ack, out_kill}), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(out_valid == '0 && out_ack == '0 && out_kill == '0, "R1", "outputs after reset",
              64'({out_valid, out_ack, out_kill}), 64'd0);
        mon_en = 1'b1;
        settle(2);

        // R2 R3 R4 R5: West -> East broadcast
        d1 = mk(2, 1, 16'h0A01);
        put(3, d1, 2'd2); want(cyc, 5'b10111, 5'b00010, 5'b10101, d1, 2'd2, "R2");
        step(); settle(4);

        // R3: Local -> North
        d1 = mk(1, 2, 16'h0A02);
        put(4, d1, 2'd1); want(cyc, 5'b01111, 5'b00001, 5'b01110, d1, 2'd1, "R3");
        step(); settle(4);

        // R3: North -> Local
        d1 = mk(1, 1, 16'h0A03);
        put(0, d1, 2'd3); want(cyc, 5'b11110, 5'b10000, 5'b01110, d1, 2'd3, "R3");
        step(); settle(4);

        // R3: East -> South
        d1 = mk(1, 0, 16'h0A04);
        put(1, d1, 2'd0); want(cyc, 5'b11101, 5'b00100, 5'b11001, d1, 2'd0, "R5");
        step(); settle(4);

        // R3: South -> West
        d1 = mk(0, 1, 16'h0A05);
        put(2, d1, 2'd1); want(cyc, 5'b11011, 5'b01000, 5'b10011, d1, 2'd1, "R4");
        step(); settle(4);

        // R6 R8: North and South together; North served first
        c  = cyc;
        d1 = mk(2, 1, 16'h0B01);
        d2 = mk(0, 1, 16'h0B02);
        put(0, d1, 2'd1); put(2, d2, 2'd2);
        want(c + 4, 5'b00010, 5'b00010, 5'b00000, d1, 2'd1, "R8");
        want(c + 9, 5'b01000, 5'b01000, 5'b00000, d2, 2'd2, "R6");
        step(); settle(14);

        // R9: two together, then a lone flit while busy is held
        c  = cyc;
        d1 = mk(1, 2, 16'h0C01);
        d2 = mk(1, 0, 16'h0C02);
        d3 = mk(1, 1, 16'h0C03);
        put(1, d1, 2'd0); put(2, d2, 2'd3);
        want(c + 4,  5'b00001, 5'b00001, 5'b00000, d1, 2'd0, "R6");
        want(c + 9,  5'b00100, 5'b00100, 5'b00000, d2, 2'd3, "R6");
        want(c + 14, 5'b10000, 5'b10000, 5'b00000, d3, 2'd1, "R9");
        step();
        @(negedge clk);
        put(3, d3, 2'd1);
        step(); settle(18);

        // R7: a non-route candidate lacks credit
        out_ready[2] = 1'b0;
        c  = cyc;
        d1 = mk(2, 1, 16'h0D01);
        put(3, d1, 2'd2);
        want(c + 4, 5'b00010, 5'b00010, 5'b00000, d1, 2'd2, "R7");
        step(); settle(8);
        out_ready[2] = 1'b1;
        settle(2);

        // R11: route port lacks credit until cycle c+6
        out_ready[1] = 1'b0;
        c  = cyc;
        d1 = mk(3, 2, 16'h0E01);
        put(4, d1, 2'd3);
        want(c + 7, 5'b00010, 5'b00010, 5'b00000, d1, 2'd3, "R11");
        step();
        settle(5);
        out_ready[1] = 1'b1;
        settle(8);

        check(q.size() == 0, "R8", "scoreboard drained", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule